// File: doc/BRIEF.md
# Sparse Parallel-Prefix Binary Adder

This block adds two unsigned operands of parameterizable width together with a single carry-in bit. It returns the truncated sum and a carry-out. Every bit column first forms a generate/propagate pair. Those pairs are folded into one pair per segment of `SPARSITY` adjacent columns. A Kogge-Stone style logarithmic prefix tree then merges the segment pairs, so that each segment learns whether a carry reaches its lowest bit. The incoming carry enters the tree as the generate of an extra column that sits below bit 0.

With `SPARSITY` set to 1 the tree is dense, and each sum bit is the column's a XOR b XOR its own carry. With `SPARSITY` set to 2 or 4 the tree only produces a carry at every segment boundary. Inside each segment, two short additions run side by side, one assuming a carry-in of zero and one assuming one, and the tree carry picks between them.

`OUT_REG` selects whether the result leaves through a register stage with an asynchronous active-low reset or straight from the logic. `WIDTH` must be a power of two that `SPARSITY` divides; an illegal pairing stops elaboration with an error.

Top module: `sparse_prefix_adder`

## Requirements
- R1: For all operand values, {cout_o, sum_o} equals a_i + b_i + cin_i as a WIDTH+1 bit result, with cout_o holding bit WIDTH.
- R2: With both operands zero, cin_i = 1 gives sum_o = 1 and cout_o = 0, and cin_i = 0 gives an all-zero result.
- R3: An all-ones operand plus one wraps to sum_o = 0 with cout_o = 1, whether the one comes from b_i (cin_i = 0) or from cin_i (b_i = 0).
- R4: When a_i XOR b_i is all ones (for example alternating 1010... against 0101...), sum_o is all ones and cout_o is 0 for cin_i = 0, and sum_o is zero and cout_o is 1 for cin_i = 1.
- R5: With SPARSITY = 1, the tree supplies a carry to every column and the result still obeys R1.
- R6: With SPARSITY = k > 1, the carry into each bit position that is a multiple of k equals the arithmetic carry out of all lower bits plus cin_i. A lower region of all ones plus one carries across the boundary into the next segment.
- R7: With OUT_REG = 1, outputs change only at the rising edge of clk_i and show the result of the inputs present at that edge. Input changes between edges leave the outputs unchanged.
- R8: With OUT_REG = 0, outputs follow the inputs combinationally with no clock edge needed.
- R9: With OUT_REG = 1, while rst_ni is low the outputs read sum_o = 0 and cout_o = 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, truncated to WIDTH bits |
| cout_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The hardest case to reach is a carry that starts in the lowest column (or at cin_i) and has to cross every segment boundary through the prefix tree. Random operands almost never make every column propagate. The stimulus forces this case directly: alternating-bit operands, all-ones plus one, and operands whose lower k·j bits are all ones plus one, for every boundary j. The 8-bit sparse instance is also swept over all 2^17 operand and carry combinations, and an internal check compares each segment-boundary carry against the arithmetic carry of the lower bits.

// File: rtl/spa_pkg.sv
package spa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a more significant group with the adjacent less significant one.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t res;
        res.g = hi.g | (hi.p & lo.g);
        res.p = hi.p & lo.p;
        return res;
    endfunction

endpackage

// File: rtl/spa_seg_gp.sv
module spa_seg_gp
    import spa_pkg::*;
#(
    parameter int unsigned SEG_W = 4
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    output gp_t              gp_o
);

    gp_t [SEG_W-1:0] col;
    gp_t [SEG_W-1:0] acc;

    for (genvar i = 0; i < SEG_W; i++) begin : g_col
        assign col[i].g = a_i[i] & b_i[i];
        assign col[i].p = a_i[i] ^ b_i[i];
        if (i == 0) begin : g_first
            assign acc[i] = col[i];
        end else begin : g_chain
            assign acc[i] = gp_merge(col[i], acc[i-1]);
        end
    end

    assign gp_o = acc[SEG_W-1];

endmodule

// File: rtl/spa_prefix_tree.sv
module spa_prefix_tree
    import spa_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  gp_t [N-1:0] leaf_i,
    output gp_t [N-1:0] pre_o
);

    localparam int unsigned LVL = (N > 1) ? $clog2(N) : 0;

    gp_t [N-1:0] stage [LVL+1];

    assign stage[0] = leaf_i;

    for (genvar lv = 0; lv < LVL; lv++) begin : g_lvl
        localparam int unsigned SPAN = 1 << lv;
        for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= SPAN) begin : g_merge
                assign stage[lv+1][i] = gp_merge(stage[lv][i], stage[lv][i-SPAN]);
            end else begin : g_pass
                assign stage[lv+1][i] = stage[lv][i];
            end
        end
    end

    assign pre_o = stage[LVL];

endmodule

// File: rtl/spa_cond_sum.sv
module spa_cond_sum #(
    parameter int unsigned SEG_W = 4
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    input  logic             cin_i,
    output logic [SEG_W-1:0] sum_o
);

    logic [SEG_W-1:0] sum_zero;
    logic [SEG_W-1:0] sum_one;

    assign sum_zero = a_i + b_i;
    assign sum_one  = a_i + b_i + SEG_W'(1);
    assign sum_o    = cin_i ? sum_one : sum_zero;

endmodule

// File: rtl/sparse_prefix_adder.sv
module sparse_prefix_adder
    import spa_pkg::*;
#(
    parameter int unsigned WIDTH    = 64,
    parameter int unsigned SPARSITY = 4,
    parameter bit          OUT_REG  = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int unsigned NSEG = WIDTH / SPARSITY;

    if (((WIDTH % SPARSITY) != 0) || !((SPARSITY == 1) || (SPARSITY == 2) || (SPARSITY == 4))
        || ((WIDTH & (WIDTH - 1)) != 0)) begin : g_bad_param
        $error("sparse_prefix_adder: WIDTH must be a power of two divisible by SPARSITY in {1,2,4}");
    end

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } res_t;

    gp_t [NSEG-1:0] seg_gp;
    gp_t [NSEG-1:0] seg_leaf;
    gp_t [NSEG-1:0] seg_pre;
    gp_t            cin_gp;
    logic [NSEG-1:0] seg_cin;
    logic [WIDTH-1:0] sum_w;

    res_t res_d;
    res_t res_q;

    // Carry-in acts as the generate of a virtual column under bit 0.
    assign cin_gp.g = cin_i;
    assign cin_gp.p = 1'b0;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        spa_seg_gp #(
            .SEG_W(SPARSITY)
        ) u_seg_gp (
            .a_i (a_i[s*SPARSITY +: SPARSITY]),
            .b_i (b_i[s*SPARSITY +: SPARSITY]),
            .gp_o(seg_gp[s])
        );

        if (s == 0) begin : g_lsb
            assign seg_leaf[s] = gp_merge(seg_gp[s], cin_gp);
            assign seg_cin[s]  = cin_i;
        end else begin : g_upper
            assign seg_leaf[s] = seg_gp[s];
            assign seg_cin[s]  = seg_pre[s-1].g;
        end

        if (SPARSITY == 1) begin : g_dense
            assign sum_w[s] = a_i[s] ^ b_i[s] ^ seg_cin[s];
        end else begin : g_sparse
            spa_cond_sum #(
                .SEG_W(SPARSITY)
            ) u_cond_sum (
                .a_i  (a_i[s*SPARSITY +: SPARSITY]),
                .b_i  (b_i[s*SPARSITY +: SPARSITY]),
                .cin_i(seg_cin[s]),
                .sum_o(sum_w[s*SPARSITY +: SPARSITY])
            );
        end
    end

    spa_prefix_tree #(
        .N(NSEG)
    ) u_tree (
        .leaf_i(seg_leaf),
        .pre_o (seg_pre)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_w;
        res_d.cout = seg_pre[NSEG-1].g;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    if (OUT_REG) begin : g_out_reg
        assign sum_o  = res_q.sum;
        assign cout_o = res_q.cout;
    end else begin : g_out_comb
        assign sum_o  = res_d.sum;
        assign cout_o = res_d.cout;
    end

endmodule

// File: rtl/spa_adder_chk.sv
module spa_adder_chk #(
    parameter int unsigned WIDTH    = 64,
    parameter int unsigned SPARSITY = 4,
    parameter bit          OUT_REG  = 1'b1
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [WIDTH-1:0]          a_i,
    input logic [WIDTH-1:0]          b_i,
    input logic                      cin_i,
    input logic [WIDTH-1:0]          sum_o,
    input logic                      cout_o,
    input logic [WIDTH/SPARSITY-1:0] seg_cin_i
);

    localparam int unsigned NSEG = WIDTH / SPARSITY;

    logic [NSEG-1:0] exp_seg;

    for (genvar j = 0; j < NSEG; j++) begin : g_exp
        localparam int unsigned LOWB = j * SPARSITY;
        logic [WIDTH:0] msk;
        logic [WIDTH:0] low;
        assign msk = ((WIDTH+1)'(1) << LOWB) - (WIDTH+1)'(1);
        assign low = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk) + (WIDTH+1)'(cin_i);
        assign exp_seg[j] = low[LOWB];
    end

    // R6
    seg_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_cin_i == exp_seg);

    if (OUT_REG) begin : g_reg_chk
        // R1
        sum_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) |-> {cout_o, sum_o} ==
                ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + (WIDTH+1)'($past(cin_i))));

        // R2
        cin_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && ($past(a_i) == '0) && ($past(b_i) == '0))
                |-> (!cout_o && (sum_o == WIDTH'($past(cin_i)))));

        // R4
        full_prop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && (&($past(a_i) ^ $past(b_i))))
                |-> ((cout_o == $past(cin_i)) && (sum_o == {WIDTH{~$past(cin_i)}})));

        // R9
        reset_clear_chk: assert property (@(posedge clk_i)
            !rst_ni |-> ((sum_o == '0) && !cout_o));
    end else begin : g_comb_chk
        // R1
        sum_comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            {cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)));

        // R2
        cin_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((a_i == '0) && (b_i == '0)) |-> (!cout_o && (sum_o == WIDTH'(cin_i))));

        // R4
        full_prop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (&(a_i ^ b_i)) |-> ((cout_o == cin_i) && (sum_o == {WIDTH{~cin_i}})));
    end

endmodule

bind sparse_prefix_adder spa_adder_chk #(
    .WIDTH   (WIDTH),
    .SPARSITY(SPARSITY),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (cin_i),
    .sum_o    (sum_o),
    .cout_o   (cout_o),
    .seg_cin_i(seg_cin)
);

// File: tb/sparse_prefix_adder_tb_top.sv
`timescale 1ns/1ps
module sparse_prefix_adder_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;

    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [63:0] aw, bw, sw;
    logic        cw, cow;
    logic [15:0] ad, bd, sd;
    logic        cd, cod;

    int n_vec = 0;
    int n_bad = 0;

    sparse_prefix_adder #(.WIDTH(8), .SPARSITY(2), .OUT_REG(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .a_i(a8), .b_i(b8), .cin_i(c8),
        .sum_o(s8), .cout_o(co8));

    sparse_prefix_adder #(.WIDTH(64), .SPARSITY(4), .OUT_REG(1'b1)) dut_w_i (
        .clk_i(clk), .rst_ni(rst_n), .a_i(aw), .b_i(bw), .cin_i(cw),
        .sum_o(sw), .cout_o(cow));

    sparse_prefix_adder #(.WIDTH(16), .SPARSITY(1), .OUT_REG(1'b0)) dut_d_i (
        .clk_i(clk), .rst_ni(rst_n), .a_i(ad), .b_i(bd), .cin_i(cd),
        .sum_o(sd), .cout_o(cod));

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_w(input logic [63:0] a, input logic [63:0] b, input logic c,
                         input string req);
        @(negedge clk);
        aw = a; bw = b; cw = c;
        @(negedge clk);
        chk(req, {cow, sw}, {1'b0, a} + {1'b0, b} + 65'(c));
    endtask

    task automatic run_d(input logic [15:0] a, input logic [15:0] b, input logic c,
                         input string req);
        @(negedge clk);
        ad = a; bd = b; cd = c;
        #1;
        chk(req, 65'({cod, sd}), 65'({1'b0, a} + {1'b0, b} + 17'(c)));
    endtask

    initial begin
        logic [8:0] exp_prev;
        rst_n = 1'b1;
        a8 = '0; b8 = '0; c8 = 1'b0;
        aw = '0; bw = '0; cw = 1'b0;
        ad = '0; bd = '0; cd = 1'b0;
        #1 rst_n = 1'b0;
        a8 = 8'hFF; b8 = 8'h01; c8 = 1'b1;
        aw = '1; bw = 64'd1; cw = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 narrow", 65'({co8, s8}), 65'd0);
        chk("R9 wide", {cow, sw}, 65'd0);
        a8 = '0; b8 = '0; c8 = 1'b0;
        aw = '0; bw = '0; cw = 1'b0;
        rst_n = 1'b1;
        #1;
        chk("R9 after release", 65'({co8, s8}), 65'd0);

        // Exhaustive sweep of the 8-bit sparse registered instance: R1, R3, R4, R6, R7
        exp_prev = '0;
        for (int i = 0; i < 131072; i++) begin
            @(negedge clk);
            chk("R1 exhaustive", 65'({co8, s8}), 65'(exp_prev));
            a8 = i[7:0]; b8 = i[15:8]; c8 = i[16];
            #1;
            chk("R7 hold", 65'({co8, s8}), 65'(exp_prev));
            exp_prev = {1'b0, a8} + {1'b0, b8} + 9'(c8);
        end
        @(negedge clk);
        chk("R1 exhaustive", 65'({co8, s8}), 65'(exp_prev));

        // Wide default-shaped instance
        run_w(64'd0, 64'd0, 1'b1, "R2");
        run_w(64'd0, 64'd0, 1'b0, "R2");
        run_w('1, 64'd1, 1'b0, "R3");
        run_w('1, 64'd0, 1'b1, "R3");
        run_w({32{2'b10}}, {32{2'b01}}, 1'b0, "R4");
        run_w({32{2'b10}}, {32{2'b01}}, 1'b1, "R4");
        run_w({32{2'b01}}, {32{2'b10}}, 1'b1, "R4");
        for (int k = 1; k < 16; k++) begin
            run_w((64'd1 << (4*k)) - 64'd1, 64'd1, 1'b0, "R6");
            run_w((64'd1 << (4*k)) - 64'd1, 64'd0, 1'b1, "R6");
            run_w(64'hF << (4*k - 4), 64'h1 << (4*k - 4), 1'b0, "R6");
        end
        for (int n = 0; n < 3000; n++) begin
            run_w({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
        end

        // Dense combinational instance
        run_d('1, 16'd1, 1'b0, "R5 R8 R3");
        run_d({8{2'b10}}, {8{2'b01}}, 1'b1, "R5 R8 R4");
        run_d(16'd0, 16'd0, 1'b1, "R5 R8 R2");
        for (int k = 0; k < 16; k++) begin
            run_d((16'd1 << k) - 16'd1, 16'd1, 1'b0, "R5 R8");
            run_d((16'd1 << k) - 16'd1, 16'd0, 1'b1, "R5 R8");
        end
        for (int n = 0; n < 4000; n++) begin
            run_d(16'($urandom), 16'($urandom), 1'($urandom), "R5 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule